// File: doc/BRIEF.md
# Timer Command Byte Decoder

This block sits behind the command port of a five-channel counter/timer. Each byte written there is decoded in one of two ways. A byte whose top three bits are zero reloads a register pointer. That pointer names a register group and an element within that group, and it tells the surrounding register file which register the 8-bit data port currently reaches. Any other byte applies a counter operation to a chosen set of counters: arm, load, load-and-arm, save, disarm, or disarm-and-save. A five-bit field in the byte picks the counters, one bit per counter. The byte 0xFF is a master reset.

The block also tracks which half of a 16-bit register the next data-port access moves: the low byte goes first, then the high byte. Unless the sequence-hold input is high, the block advances the pointer after each high-byte access. The sequence-hold input reflects bit 14 of the master mode register, which lives outside this block. The counters and registers themselves are outside the block. They act on its one-cycle strobes and on its pointer and phase outputs.

Top module: `ctc_cmd_decoder`

## Requirements
- R1: A command byte with bits [7:5]=000 and a legal group code in bits [2:0] loads the pointer one cycle later. Legal group codes are 1 to 5 for the counters and 7 for the control group. The pointer group takes bits [2:0]. The pointer element takes bits [4:3], where 0 is mode, 1 is load, 2 is hold and 3 is hold with group increment. The byte phase returns to low.
- R2: A pointer command whose group code is 0 or 6 changes neither the pointer nor the byte phase. The pointer group never holds 0 or 6.
- R3: For other commands, bits [7:5] select the operation. 001 is arm, 010 is load, 011 is load and arm, 100 is disarm and save, 101 is save, and 110 is disarm. Bit k of bits [4:0] drives the strobe of counter k+1. A zero bit drives no strobe for that counter.
- R4: Operation strobes are high for exactly the one cycle after the command write. No strobe is high in a cycle that does not follow a command write.
- R5: The byte 0xFF pulses the master reset strobe and the disarm strobes of all five counters. It returns the byte phase to low and leaves the pointer as it was. Any other byte with bits [7:5]=111 has no effect.
- R6: Every data-port access, read or write, flips the byte phase (0 = low byte next, 1 = high byte next). The pointer stays put after a low-byte access.
- R7: When sequence-hold is low, a high-byte access advances the pointer. In a counter group, mode moves to load and load moves to hold. Hold moves to mode of the next group. Hold-with-increment stays at that element and moves to the next group. Group 5 wraps to group 1. The control group does not move.
- R8: When sequence-hold is high, data-port accesses never change the pointer.
- R9: After reset the pointer is group 1, element mode, the phase is low and all strobes are low.
- R10: A command write and a data access in the same cycle: the command acts and the data access is dropped, so it does not flip the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| data_wr | input | 1 | Data-port write access |
| data_rd | input | 1 | Data-port read access |
| seq_hold | input | 1 | High disables pointer auto-sequencing |
| ptr_group | output | 3 | Current register group |
| ptr_elem | output | 2 | Current element within the group |
| phase_hi | output | 1 | High when the next access moves the high byte |
| arm_stb | output | 5 | Per-counter arm strobes |
| load_stb | output | 5 | Per-counter load strobes |
| disarm_stb | output | 5 | Per-counter disarm strobes |
| save_stb | output | 5 | Per-counter save strobes |
| mreset_stb | output | 1 | Master reset strobe |

## Verification
The assertions check the following on every cycle:
- no strobe appears without a preceding command write;
- a master reset always carries all disarm strobes and a low phase;
- the pointer group never holds an illegal code;
- a data access flips the phase;
- the pointer stays frozen under sequence-hold or after a low-byte access.

The exact opcode-to-strobe mapping and the mask bit order need the bench's scenarios. So do the pointer's successor in each element, the group wrap and the control-group case, and the command-over-data priority.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    localparam int GRP_W = 3;
    localparam int ELM_W = 2;
    localparam logic [GRP_W-1:0] GRP_CTL = 3'd7;

    typedef enum logic [2:0] {
        OP_PTR    = 3'b000,
        OP_ARM    = 3'b001,
        OP_LOAD   = 3'b010,
        OP_LDARM  = 3'b011,
        OP_DISSAV = 3'b100,
        OP_SAVE   = 3'b101,
        OP_DISARM = 3'b110,
        OP_CTRL   = 3'b111
    } op_e;

    typedef enum logic [ELM_W-1:0] {
        EL_MODE  = 2'd0,
        EL_LOAD  = 2'd1,
        EL_HOLD  = 2'd2,
        EL_HOLDI = 2'd3
    } elem_e;
endpackage

// File: rtl/ctc_cmd_classify.sv
module ctc_cmd_classify
    import ctc_pkg::*;
#(
    parameter int N_CTR = 5
) (
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic             ptr_load,
    output logic [GRP_W-1:0] ptr_group,
    output logic [ELM_W-1:0] ptr_elem,
    output logic [N_CTR-1:0] arm_m,
    output logic [N_CTR-1:0] load_m,
    output logic [N_CTR-1:0] dis_m,
    output logic [N_CTR-1:0] save_m,
    output logic             mreset
);
    op_e              op;
    logic [N_CTR-1:0] mask;
    logic             grp_ok;
    logic             do_arm, do_load, do_dis, do_save;

    assign op        = op_e'(cmd_byte[7:5]);
    assign mask      = cmd_byte[N_CTR-1:0];
    assign ptr_group = cmd_byte[GRP_W-1:0];
    assign ptr_elem  = cmd_byte[4:3];

    always_comb begin
        grp_ok  = ((ptr_group != '0) && (32'(ptr_group) <= N_CTR))
                  || (ptr_group == GRP_CTL);
        do_arm  = (op == OP_ARM)    || (op == OP_LDARM);
        do_load = (op == OP_LOAD)   || (op == OP_LDARM);
        do_dis  = (op == OP_DISSAV) || (op == OP_DISARM);
        do_save = (op == OP_DISSAV) || (op == OP_SAVE);
    end

    assign ptr_load = cmd_valid && (op == OP_PTR) && grp_ok;
    assign mreset   = cmd_valid && (cmd_byte == 8'hFF);

    for (genvar k = 0; k < N_CTR; k++) begin : g_ctr
        assign arm_m[k]  = cmd_valid && mask[k] && do_arm;
        assign load_m[k] = cmd_valid && mask[k] && do_load;
        assign dis_m[k]  = cmd_valid && mask[k] && do_dis;
        assign save_m[k] = cmd_valid && mask[k] && do_save;
    end
endmodule

// File: rtl/ctc_ptr_step.sv
module ctc_ptr_step
    import ctc_pkg::*;
#(
    parameter int N_CTR = 5
) (
    input  logic [GRP_W-1:0] grp_in,
    input  logic [ELM_W-1:0] elm_in,
    output logic [GRP_W-1:0] grp_out,
    output logic [ELM_W-1:0] elm_out
);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(N_CTR);
    logic [GRP_W-1:0] grp_next;

    assign grp_next = (grp_in == GRP_LAST) ? GRP_W'(1) : grp_in + GRP_W'(1);

    always_comb begin
        grp_out = grp_in;
        elm_out = elm_in;
        if (grp_in != GRP_CTL) begin
            unique case (elem_e'(elm_in))
                EL_MODE:  elm_out = EL_LOAD;
                EL_LOAD:  elm_out = EL_HOLD;
                EL_HOLD: begin
                    elm_out = EL_MODE;
                    grp_out = grp_next;
                end
                EL_HOLDI: grp_out = grp_next;
            endcase
        end
    end
endmodule

// File: rtl/ctc_cmd_decoder.sv
module ctc_cmd_decoder
    import ctc_pkg::*;
#(
    parameter int N_CTR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_byte,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic             seq_hold,
    output logic [2:0]       ptr_group,
    output logic [1:0]       ptr_elem,
    output logic             phase_hi,
    output logic [N_CTR-1:0] arm_stb,
    output logic [N_CTR-1:0] load_stb,
    output logic [N_CTR-1:0] disarm_stb,
    output logic [N_CTR-1:0] save_stb,
    output logic             mreset_stb
);
    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [ELM_W-1:0] elm;
        logic             hi;
        logic [N_CTR-1:0] arm;
        logic [N_CTR-1:0] ld;
        logic [N_CTR-1:0] dis;
        logic [N_CTR-1:0] sav;
        logic             mr;
    } st_t;

    st_t st_d, st_q;

    logic             c_ptr_load, c_mreset;
    logic [GRP_W-1:0] c_grp, s_grp;
    logic [ELM_W-1:0] c_elm, s_elm;
    logic [N_CTR-1:0] c_arm, c_ld, c_dis, c_sav;
    logic             data_acc;

    assign data_acc = data_wr || data_rd;

    ctc_cmd_classify #(.N_CTR(N_CTR)) u_classify (
        .cmd_valid (cmd_wr),
        .cmd_byte  (cmd_byte),
        .ptr_load  (c_ptr_load),
        .ptr_group (c_grp),
        .ptr_elem  (c_elm),
        .arm_m     (c_arm),
        .load_m    (c_ld),
        .dis_m     (c_dis),
        .save_m    (c_sav),
        .mreset    (c_mreset)
    );

    ctc_ptr_step #(.N_CTR(N_CTR)) u_step (
        .grp_in  (st_q.grp),
        .elm_in  (st_q.elm),
        .grp_out (s_grp),
        .elm_out (s_elm)
    );

    always_comb begin
        st_d     = st_q;
        st_d.arm = c_arm;
        st_d.ld  = c_ld;
        st_d.dis = c_dis | {N_CTR{c_mreset}};
        st_d.sav = c_sav;
        st_d.mr  = c_mreset;
        if (cmd_wr) begin
            if (c_ptr_load) begin
                st_d.grp = c_grp;
                st_d.elm = c_elm;
                st_d.hi  = 1'b0;
            end
            if (c_mreset) begin
                st_d.hi = 1'b0;
            end
        end else if (data_acc) begin
            if (!st_q.hi) begin
                st_d.hi = 1'b1;
            end else begin
                st_d.hi = 1'b0;
                if (!seq_hold) begin
                    st_d.grp = s_grp;
                    st_d.elm = s_elm;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.grp <= GRP_W'(1);
            st_q.elm <= EL_MODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_group  = st_q.grp;
    assign ptr_elem   = st_q.elm;
    assign phase_hi   = st_q.hi;
    assign arm_stb    = st_q.arm;
    assign load_stb   = st_q.ld;
    assign disarm_stb = st_q.dis;
    assign save_stb   = st_q.sav;
    assign mreset_stb = st_q.mr;

    // R4: strobes only in the cycle after a command write
    a_r4_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> (arm_stb == '0 && load_stb == '0 && disarm_stb == '0
                     && save_stb == '0 && !mreset_stb));

    // R5: master reset carries all disarms and a low phase
    a_r5_mreset_full: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_stb |-> (disarm_stb == '1 && !phase_hi));

    // R2: pointer group never illegal
    a_r2_group_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_group != 3'd0 && ptr_group != 3'd6));

    // R6: data access flips the phase
    a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && data_acc) |=> (phase_hi != $past(phase_hi)));

    // R6: low-byte access leaves the pointer alone
    a_r6_lsb_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && data_acc && !phase_hi) |=> ($stable(ptr_group) && $stable(ptr_elem)));

    // R8: sequence hold freezes the pointer without commands
    a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && seq_hold) |=> ($stable(ptr_group) && $stable(ptr_elem)));
endmodule

// File: tb/ctc_cmd_decoder_bench.sv
module ctc_cmd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       data_wr = 1'b0;
    logic       data_rd = 1'b0;
    logic       seq_hold = 1'b0;
    logic [2:0] ptr_group;
    logic [1:0] ptr_elem;
    logic       phase_hi;
    logic [4:0] arm_stb, load_stb, disarm_stb, save_stb;
    logic       mreset_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctc_cmd_decoder u_ctc_cmd_decoder (
        .clk, .rst_n, .cmd_wr, .cmd_byte, .data_wr, .data_rd, .seq_hold,
        .ptr_group, .ptr_elem, .phase_hi, .arm_stb, .load_stb,
        .disarm_stb, .save_stb, .mreset_stb
    );

    // {cmd, arm, load, disarm, save, mreset}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {8'h21, 5'h01, 5'h00, 5'h00, 5'h00, 1'b0},
        {8'h3F, 5'h1F, 5'h00, 5'h00, 5'h00, 1'b0},
        {8'h43, 5'h00, 5'h03, 5'h00, 5'h00, 1'b0},
        {8'h5A, 5'h00, 5'h1A, 5'h00, 5'h00, 1'b0},
        {8'h65, 5'h05, 5'h05, 5'h00, 5'h00, 1'b0},
        {8'h9C, 5'h00, 5'h00, 5'h1C, 5'h1C, 1'b0},
        {8'hA3, 5'h00, 5'h00, 5'h00, 5'h03, 1'b0},
        {8'hC2, 5'h00, 5'h00, 5'h02, 5'h00, 1'b0},
        {8'hD1, 5'h00, 5'h00, 5'h11, 5'h00, 1'b0},
        {8'hFF, 5'h00, 5'h00, 5'h1F, 5'h00, 1'b1},
        {8'hE5, 5'h00, 5'h00, 5'h00, 5'h00, 1'b0},
        {8'h09, 5'h00, 5'h00, 5'h00, 5'h00, 1'b0},
        {8'h20, 5'h00, 5'h00, 5'h00, 5'h00, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_ptr(input string tag, input int g, input int e, input bit h);
        chk(tag, {26'd0, ptr_group, ptr_elem, phase_hi}, {26'd0, 3'(g), 2'(e), h});
    endtask

    task automatic strobes_now(output logic [20:0] s);
        s = {arm_stb, load_stb, disarm_stb, save_stb, mreset_stb};
    endtask

    task automatic do_cmd(input logic [7:0] b, input bit with_data);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_byte = b; data_wr = with_data;
        @(negedge clk);
        cmd_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic xfer(input bit rd);
        @(negedge clk);
        if (rd) data_rd = 1'b1; else data_wr = 1'b1;
        @(negedge clk);
        data_rd = 1'b0; data_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [20:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_ptr("R9 reset pointer/phase", 1, 0, 1'b0);
        strobes_now(s);
        chk("R9 reset strobes", {11'd0, s}, 32'd0);

        // R3/R4/R5 operation table
        for (int i = 0; i < NV; i++) begin
            do_cmd(VEC[i][28:21], 1'b0);
            strobes_now(s);
            chk($sformatf("R3 R5 op byte %h", VEC[i][28:21]), {11'd0, s}, {11'd0, VEC[i][20:0]});
            @(negedge clk);
            strobes_now(s);
            chk("R4 strobe lasts one cycle", {11'd0, s}, 32'd0);
        end

        do_cmd(8'h0B, 1'b0); chk_ptr("R1 pointer load g3 load", 3, 1, 1'b0);
        do_cmd(8'h10, 1'b0); chk_ptr("R2 group 0 ignored", 3, 1, 1'b0);
        do_cmd(8'h16, 1'b0); chk_ptr("R2 group 6 ignored", 3, 1, 1'b0);
        xfer(1'b0);          chk_ptr("R6 low byte keeps ptr", 3, 1, 1'b1);
        xfer(1'b0);          chk_ptr("R7 load->hold", 3, 2, 1'b0);
        xfer(1'b1); xfer(1'b1); chk_ptr("R7 hold->next mode", 4, 0, 1'b0);
        do_cmd(8'h15, 1'b0); xfer(1'b0); xfer(1'b0);
        chk_ptr("R7 group 5 wraps", 1, 0, 1'b0);
        do_cmd(8'h1A, 1'b0); xfer(1'b0); xfer(1'b0);
        chk_ptr("R7 hold-incr steps group", 3, 3, 1'b0);
        do_cmd(8'h07, 1'b0); xfer(1'b0); xfer(1'b0);
        chk_ptr("R7 control group stays", 7, 0, 1'b0);

        seq_hold = 1'b1;
        do_cmd(8'h09, 1'b0); chk_ptr("R8 cmd works under hold", 1, 1, 1'b0);
        xfer(1'b0); xfer(1'b1);
        chk_ptr("R8 no auto-sequence", 1, 1, 1'b0);
        seq_hold = 1'b0;

        xfer(1'b0);
        do_cmd(8'h21, 1'b1);
        chk_ptr("R10 data dropped on cmd", 1, 1, 1'b1);
        chk("R10 cmd still acts", {27'd0, arm_stb}, 32'd1);

        do_cmd(8'hFF, 1'b0);
        chk_ptr("R5 mreset phase low ptr kept", 1, 1, 1'b0);

        xfer(1'b0);
        do_cmd(8'h0A, 1'b0); chk_ptr("R1 ptr cmd resets phase", 2, 1, 1'b0);
        xfer(1'b0);
        do_cmd(8'h16, 1'b0); chk_ptr("R2 illegal keeps phase", 2, 1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule